// File: doc/BRIEF.md
# Recursive Rayleigh Fading Coefficient Generator

This block produces the envelope of one fading channel tap. It holds a bank of second-order recursive sinusoid oscillators: one in-phase and one quadrature oscillator for each multipath component. Each oscillator keeps only its last two samples. It advances by one multiply, one rounding step and one subtract per update, so no cosine table is needed while it runs.

The oscillator sums are reduced to an envelope. The in-phase outputs of all components are summed, and so are the quadrature outputs. A bit-serial square root of the sum of the two squares is then divided by the component count.

Software or a seeding engine first writes every component's coefficient and its two starting samples through the seed port. After that, each update strobe yields one envelope sample. The strobe rate is far below the clock rate, and the update interval must stay shorter than the inverse of the largest Doppler shift being emulated. Only one sample is computed at a time.

Top module: `rayleigh_fade_gen`

## Requirements
- R1: After reset, envValid is 0 and envOut is 0, and the block is waiting for seeds. Any update strobe is ignored until a full set of NUM_COMP seed beats has been written.
- R2: A pulse on seedStart opens a seed load. The next NUM_COMP cycles with seedValid high load components 0, 1, … NUM_COMP-1 in that order. Each beat carries the coefficient, the older I sample (seedI0), the newer I sample (seedI1), and the matching Q samples (seedQ0, seedQ1). Strobes that arrive before the last beat are ignored.
- R3: Samples and coefficients are two's complement, SAMPLE_W bits wide, with SAMPLE_W-2 fractional bits. Each accepted strobe moves every oscillator one step. With B the coefficient, y1 the newer sample and y0 the older sample, the new sample is sat(((B*y1 + 2^(SAMPLE_W-3)) >>> (SAMPLE_W-2)) - y0). Here >>> is an arithmetic shift (floor). The new sample becomes the newer one and the old newer sample becomes the older one.
- R4: With SI and SQ the sums of the freshly updated I and Q samples, envOut is the unsigned value floor(floor(sqrt(SI² + SQ²)) / NUM_COMP).
- R5: envValid is high for exactly one cycle. It rises SAMPLE_W + clog2(NUM_COMP) + 2 clock edges after the edge that accepts the strobe, which is 22 edges with the default parameters. envOut holds its value until the next result.
- R6: A strobe that arrives while a sample is being computed is ignored. It does not advance the oscillators and produces no extra envValid.
- R7: A seedStart pulse during a computation abandons that computation, so no envValid follows from it. It also clears envOut to 0 on the following edge.
- R8: An oscillator result above 2^(SAMPLE_W-1)-1 is clamped to that value, and a result below -2^(SAMPLE_W-1) is clamped to -2^(SAMPLE_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedStart | input | 1 | Starts a seed load and abandons any work in progress |
| seedValid | input | 1 | Marks one seed beat for the next component in order |
| seedCoef | input | SAMPLE_W | Component coefficient, twice the cosine of its phase step |
| seedI0 | input | SAMPLE_W | Older in-phase starting sample |
| seedI1 | input | SAMPLE_W | Newer in-phase starting sample |
| seedQ0 | input | SAMPLE_W | Older quadrature starting sample |
| seedQ1 | input | SAMPLE_W | Newer quadrature starting sample |
| updStrobe | input | 1 | Requests one oscillator step and one envelope sample |
| envOut | output | SAMPLE_W | Envelope sample, unsigned, same fractional scaling as the inputs |
| envValid | output | 1 | One-cycle pulse when envOut is fresh |

## Verification
The assertions assume that seedValid is driven only during a seed load. They also assume that the oscillators stay frozen from an accepted strobe until its result, which is why the root check can recompute the radicand from live sums. The bench keeps to these assumptions. It raises seedValid only right after seedStart, for exactly NUM_COMP beats. It sends strobes either when the block is idle or, on purpose, mid-computation to exercise the ignore rule. The coefficients it computes always fit inside the open range (-2, 2).

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic flush;     // abandon work, clear the output
    logic seedWr;    // write seeds of the indexed component
    logic step;      // advance every oscillator once
    logic rootInit;  // capture the radicand, clear the root
    logic rootIter;  // one bit of the square root
    logic outLoad;   // scale the root and publish it
  } rfgCtl_t;
endpackage

// File: rtl/rfg_osc.sv
module rfg_osc #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       load,
  input  logic                       step,
  input  logic signed [SAMPLE_W-1:0] coef,
  input  logic signed [SAMPLE_W-1:0] seedOld,
  input  logic signed [SAMPLE_W-1:0] seedNew,
  output logic signed [SAMPLE_W-1:0] yNow
);
  localparam int FRAC_W = SAMPLE_W - 2;
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int DIFF_W = PROD_W + 1;
  localparam logic signed [PROD_W-1:0] ROUND_C = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [DIFF_W-1:0] MAX_V = DIFF_W'((64'sd1 <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] MIN_V = -MAX_V - DIFF_W'(1);

  logic signed [SAMPLE_W-1:0] yPrev, yPrev2, yNext;
  logic signed [PROD_W-1:0]   prod, rounded;
  logic signed [DIFF_W-1:0]   diff;

  always_comb begin
    prod    = coef * yPrev;
    rounded = (prod + ROUND_C) >>> FRAC_W;
    diff    = DIFF_W'(rounded) - DIFF_W'(yPrev2);
    if (diff > MAX_V)      yNext = SAMPLE_W'(MAX_V);
    else if (diff < MIN_V) yNext = SAMPLE_W'(MIN_V);
    else                   yNext = SAMPLE_W'(diff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yPrev  <= '0;
      yPrev2 <= '0;
    end else if (load) begin
      yPrev  <= seedNew;
      yPrev2 <= seedOld;
    end else if (step) begin
      yPrev  <= yNext;
      yPrev2 <= yPrev;
    end
  end

  assign yNow = yPrev;

  // R3: the older sample takes the previous newer one on every step
  a_r3_history: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load) |=> (yPrev2 == $past(yPrev)));
  // R6: without load or step the oscillator holds its state
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !load) |=> ($stable(yPrev) && $stable(yPrev2)));
endmodule

// File: rtl/rfg_control.sv
module rfg_control
  import rfg_pkg::*;
#(
  parameter int NUM_COMP   = 10,
  parameter int ROOT_STEPS = 20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        seedStart,
  input  logic                        seedValid,
  input  logic                        updStrobe,
  output rfgCtl_t                     ctl,
  output logic [$clog2(NUM_COMP)-1:0] seedIdx
);
  localparam int IDX_W = $clog2(NUM_COMP);
  localparam int CNT_W = $clog2((NUM_COMP > ROOT_STEPS) ? NUM_COMP : ROOT_STEPS);

  typedef enum logic [2:0] {S_LOAD, S_IDLE, S_SUMS, S_ROOT, S_FINISH} state_t;
  state_t state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ctl          = '0;
    ctl.flush    = seedStart;
    ctl.seedWr   = !seedStart && (state == S_LOAD) && seedValid;
    ctl.step     = !seedStart && (state == S_IDLE) && updStrobe;
    ctl.rootInit = !seedStart && (state == S_SUMS);
    ctl.rootIter = !seedStart && (state == S_ROOT);
    ctl.outLoad  = !seedStart && (state == S_FINISH);
  end

  assign seedIdx = IDX_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rstN || seedStart) begin
      state <= S_LOAD;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_LOAD: if (seedValid) begin
          if (cnt == CNT_W'(NUM_COMP - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_IDLE:   if (updStrobe) state <= S_SUMS;
        S_SUMS: begin
          state <= S_ROOT;
          cnt   <= '0;
        end
        S_ROOT: begin
          if (cnt == CNT_W'(ROOT_STEPS - 1)) state <= S_FINISH;
          else cnt <= cnt + 1'b1;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/rfg_datapath.sv
module rfg_datapath
  import rfg_pkg::*;
#(
  parameter int NUM_COMP = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rfgCtl_t                     ctl,
  input  logic [$clog2(NUM_COMP)-1:0] seedIdx,
  input  logic signed [SAMPLE_W-1:0]  seedCoef,
  input  logic signed [SAMPLE_W-1:0]  seedI0,
  input  logic signed [SAMPLE_W-1:0]  seedI1,
  input  logic signed [SAMPLE_W-1:0]  seedQ0,
  input  logic signed [SAMPLE_W-1:0]  seedQ1,
  output logic [SAMPLE_W-1:0]         envOut,
  output logic                        envValid
);
  localparam int IDX_W = $clog2(NUM_COMP);
  localparam int SUM_W = SAMPLE_W + $clog2(NUM_COMP);
  localparam int RAD_W = 2 * SUM_W;
  localparam int REM_W = SUM_W + 4;
  localparam int CHK_W = RAD_W + 2;

  logic signed [SAMPLE_W-1:0] coefReg [NUM_COMP];
  logic signed [SAMPLE_W-1:0] iVal    [NUM_COMP];
  logic signed [SAMPLE_W-1:0] qVal    [NUM_COMP];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic wrHere;
    assign wrHere = ctl.seedWr && (seedIdx == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN)       coefReg[c] <= '0;
      else if (wrHere) coefReg[c] <= seedCoef;
    end

    rfg_osc #(.SAMPLE_W(SAMPLE_W)) oscI (
      .clk(clk), .rstN(rstN), .load(wrHere), .step(ctl.step),
      .coef(coefReg[c]), .seedOld(seedI0), .seedNew(seedI1), .yNow(iVal[c]));
    rfg_osc #(.SAMPLE_W(SAMPLE_W)) oscQ (
      .clk(clk), .rstN(rstN), .load(wrHere), .step(ctl.step),
      .coef(coefReg[c]), .seedOld(seedQ0), .seedNew(seedQ1), .yNow(qVal[c]));
  end

  logic signed [SUM_W-1:0] sumI, sumQ;
  logic signed [RAD_W-1:0] sqI, sqQ;
  logic [RAD_W-1:0]        rad;

  always_comb begin
    sumI = '0;
    sumQ = '0;
    for (int c = 0; c < NUM_COMP; c++) begin
      sumI = sumI + SUM_W'(iVal[c]);
      sumQ = sumQ + SUM_W'(qVal[c]);
    end
    sqI = RAD_W'(sumI) * RAD_W'(sumI);
    sqQ = RAD_W'(sumQ) * RAD_W'(sumQ);
    rad = sqI + sqQ;
  end

  // Non-restoring root: one radicand bit pair per cycle, remainder sign
  // chooses subtract or add.
  logic [RAD_W-1:0]        radReg;
  logic signed [REM_W-1:0] remReg, remShift, remNext;
  logic [SUM_W-1:0]        rootReg, rootNext;

  always_comb begin
    remShift = {remReg[REM_W-3:0], radReg[RAD_W-1 -: 2]};
    if (!remReg[REM_W-1]) remNext = remShift - REM_W'({rootReg, 2'b01});
    else                  remNext = remShift + REM_W'({rootReg, 2'b11});
    rootNext = {rootReg[SUM_W-2:0], ~remNext[REM_W-1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      radReg   <= '0;
      remReg   <= '0;
      rootReg  <= '0;
      envOut   <= '0;
      envValid <= 1'b0;
    end else if (ctl.flush) begin
      envOut   <= '0;
      envValid <= 1'b0;
    end else begin
      envValid <= ctl.outLoad;
      if (ctl.rootInit) begin
        radReg  <= rad;
        remReg  <= '0;
        rootReg <= '0;
      end else if (ctl.rootIter) begin
        radReg  <= radReg << 2;
        remReg  <= remNext;
        rootReg <= rootNext;
      end
      if (ctl.outLoad) envOut <= SAMPLE_W'(rootReg / SUM_W'(NUM_COMP));
    end
  end

  logic [CHK_W-1:0] rootLoSq, rootHiSq, rootHi;
  always_comb begin
    rootHi   = CHK_W'(rootReg) + CHK_W'(1);
    rootLoSq = CHK_W'(rootReg) * CHK_W'(rootReg);
    rootHiSq = rootHi * rootHi;
  end

  // R4: the finished root is the floor square root of the live radicand
  a_r4_root_floor: assert property (@(posedge clk) disable iff (!rstN)
    ctl.outLoad |-> (rootLoSq <= CHK_W'(rad)) && (rootHiSq > CHK_W'(rad)));
endmodule

// File: rtl/rayleigh_fade_gen.sv
module rayleigh_fade_gen
  import rfg_pkg::*;
#(
  parameter int NUM_COMP = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       seedStart,
  input  logic                       seedValid,
  input  logic signed [SAMPLE_W-1:0] seedCoef,
  input  logic signed [SAMPLE_W-1:0] seedI0,
  input  logic signed [SAMPLE_W-1:0] seedI1,
  input  logic signed [SAMPLE_W-1:0] seedQ0,
  input  logic signed [SAMPLE_W-1:0] seedQ1,
  input  logic                       updStrobe,
  output logic [SAMPLE_W-1:0]        envOut,
  output logic                       envValid
);
  localparam int ROOT_STEPS = SAMPLE_W + $clog2(NUM_COMP);
  localparam int LATENCY    = ROOT_STEPS + 2;
  localparam int LAT_W      = $clog2(LATENCY + 1);

  rfgCtl_t                     ctl;
  logic [$clog2(NUM_COMP)-1:0] seedIdx;

  rfg_control #(.NUM_COMP(NUM_COMP), .ROOT_STEPS(ROOT_STEPS)) uCtl (
    .clk(clk), .rstN(rstN), .seedStart(seedStart), .seedValid(seedValid),
    .updStrobe(updStrobe), .ctl(ctl), .seedIdx(seedIdx));

  rfg_datapath #(.NUM_COMP(NUM_COMP), .SAMPLE_W(SAMPLE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .seedIdx(seedIdx),
    .seedCoef(seedCoef), .seedI0(seedI0), .seedI1(seedI1),
    .seedQ0(seedQ0), .seedQ1(seedQ1), .envOut(envOut), .envValid(envValid));

  // Cycle counter from the accepted strobe, kept for the checks below.
  logic             inFlight;
  logic [LAT_W-1:0] sinceStep;
  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      inFlight  <= 1'b0;
      sinceStep <= '0;
    end else if (ctl.step) begin
      inFlight  <= 1'b1;
      sinceStep <= '0;
    end else if (inFlight) begin
      sinceStep <= sinceStep + 1'b1;
      if (ctl.outLoad) inFlight <= 1'b0;
    end
  end

  // R5: result appears a fixed number of edges after the accepted strobe
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    envValid |-> (sinceStep == LAT_W'(LATENCY)));
  // R5: valid is a single-cycle pulse
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rstN)
    envValid |=> !envValid);
  // R6: no second step while a sample is in flight
  a_r6_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !ctl.step);
  // R7: a seed start kills the output
  a_r7_flush: assert property (@(posedge clk) disable iff (!rstN)
    seedStart |=> (!envValid && envOut == '0));
endmodule

// File: tb/rayleigh_fade_gen_test.sv
module rayleigh_fade_gen_test;
  localparam int L   = 10;
  localparam int W   = 16;
  localparam int F   = W - 2;
  localparam int LAT = 22;
  localparam longint SMAX = 32767;
  localparam longint SMIN = -32768;
  // {phase step in milliradians, amplitude in thousandths, strobes}
  localparam int NVEC = 4;
  localparam int VEC [NVEC][3] = '{'{50, 800, 6}, '{200, 500, 5},
                                   '{900, 700, 4}, '{1500, 300, 4}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seedStart = 1'b0, seedValid = 1'b0, updStrobe = 1'b0;
  logic signed [W-1:0] seedCoef = '0, seedI0 = '0, seedI1 = '0, seedQ0 = '0, seedQ1 = '0;
  logic [W-1:0] envOut;
  logic envValid;

  int nChecks = 0;
  int nFail = 0;
  longint mB [L], mI0 [L], mI1 [L], mQ0 [L], mQ1 [L];

  always #5 clk = ~clk;

  rayleigh_fade_gen #(.NUM_COMP(L), .SAMPLE_W(W)) uut (
    .clk(clk), .rstN(rstN), .seedStart(seedStart), .seedValid(seedValid),
    .seedCoef(seedCoef), .seedI0(seedI0), .seedI1(seedI1),
    .seedQ0(seedQ0), .seedQ1(seedQ1), .updStrobe(updStrobe),
    .envOut(envOut), .envValid(envValid));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  task automatic checkEq(input string req, input longint got, input longint exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint oscStep(longint b, longint y1, longint y0);
    longint p, r, v;
    p = b * y1;
    r = (p + (64'sd1 <<< (F - 1))) >>> F;
    v = r - y0;
    if (v > SMAX) v = SMAX;
    if (v < SMIN) v = SMIN;
    return v;
  endfunction

  function automatic longint isqrt(longint x);
    longint r = 0;
    for (int b = 22; b >= 0; b--) begin
      longint t = r + (64'sd1 <<< b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  function automatic longint expectEnv();
    longint si = 0, sq = 0;
    for (int l = 0; l < L; l++) begin
      si += mI1[l];
      sq += mQ1[l];
    end
    return isqrt(si * si + sq * sq) / L;
  endfunction

  task automatic modelStep();
    for (int l = 0; l < L; l++) begin
      longint ni = oscStep(mB[l], mI1[l], mI0[l]);
      longint nq = oscStep(mB[l], mQ1[l], mQ0[l]);
      mI0[l] = mI1[l]; mI1[l] = ni;
      mQ0[l] = mQ1[l]; mQ1[l] = nq;
    end
  endtask

  task automatic modelSine(input int wMilli, input int ampMilli);
    for (int l = 0; l < L; l++) begin
      real w = wMilli / 1000.0 * (1.0 + 0.07 * l);
      real ph = 0.6 * l + 0.3;
      real a = ampMilli / 1000.0 * 16384.0;
      longint b = longint'($floor(2.0 * $cos(w) * 16384.0 + 0.5));
      if (b > SMAX) b = SMAX;
      if (b < -SMAX) b = -SMAX;
      mB[l]  = b;
      mI0[l] = longint'($floor(a * $cos(ph) + 0.5));
      mI1[l] = longint'($floor(a * $cos(w + ph) + 0.5));
      mQ0[l] = longint'($floor(a * $sin(ph) + 0.5));
      mQ1[l] = longint'($floor(a * $sin(w + ph) + 0.5));
    end
  endtask

  task automatic modelConst(input longint b, input longint i0, input longint i1,
                            input longint q0, input longint q1);
    for (int l = 0; l < L; l++) begin
      mB[l] = b; mI0[l] = i0; mI1[l] = i1; mQ0[l] = q0; mQ1[l] = q1;
    end
  endtask

  task automatic beat(input int l);
    seedValid = 1'b1;
    seedCoef = W'(mB[l]);
    seedI0 = W'(mI0[l]); seedI1 = W'(mI1[l]);
    seedQ0 = W'(mQ0[l]); seedQ1 = W'(mQ1[l]);
    @(negedge clk);
    seedValid = 1'b0;
  endtask

  task automatic openLoad();
    @(negedge clk) seedStart = 1'b1;
    @(negedge clk) seedStart = 1'b0;
  endtask

  task automatic driveSeeds();
    openLoad();
    for (int l = 0; l < L; l++) beat(l);
  endtask

  task automatic pulseStrobe();
    updStrobe = 1'b1;
    @(negedge clk) updStrobe = 1'b0;
  endtask

  task automatic expectQuiet(input int cycles, input string req);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (envValid) seen++;
    end
    checkEq(req, seen, 0);
  endtask

  // Strobe at a negedge, model one step, wait for the result and check it.
  task automatic strobeAndCheck(input string req);
    int n = 0;
    @(negedge clk);
    pulseStrobe();
    modelStep();
    while (!envValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    checkEq({req, " R5 latency"}, n, LAT);
    checkEq({req, " R4 envelope"}, envOut, expectEnv());
    @(negedge clk);
    checkEq({req, " R5 pulse width"}, envValid, 0);
    checkEq({req, " R5 hold"}, envOut, expectEnv());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkEq("R1 valid after reset", envValid, 0);
    checkEq("R1 output after reset", envOut, 0);
    // R1: strobe before any seed is ignored
    pulseStrobe();
    expectQuiet(40, "R1 strobe before seeding");

    // R3 R4: sinusoid seed sets from the vector table
    for (int v = 0; v < NVEC; v++) begin
      modelSine(VEC[v][0], VEC[v][1]);
      driveSeeds();
      for (int s = 0; s < VEC[v][2]; s++) strobeAndCheck("R3 recursion");
    end

    // R2: strobe during an incomplete load is ignored
    modelSine(333, 600);
    openLoad();
    for (int l = 0; l < 4; l++) beat(l);
    pulseStrobe();
    expectQuiet(30, "R2 strobe during load");
    for (int l = 4; l < L; l++) beat(l);
    strobeAndCheck("R2 first step after load");

    // R6: strobe while busy is ignored
    begin
      int n = 0;
      @(negedge clk);
      pulseStrobe();
      modelStep();
      repeat (5) @(negedge clk);
      pulseStrobe();
      n = 6;
      while (!envValid && n < 40) begin
        @(negedge clk);
        n++;
      end
      checkEq("R6 first result latency", n, LAT);
      checkEq("R6 first result value", envOut, expectEnv());
      expectQuiet(30, "R6 no extra result");
      strobeAndCheck("R6 oscillators advanced once");
    end

    // R7: seed start abandons a computation
    @(negedge clk);
    pulseStrobe();
    repeat (5) @(negedge clk);
    seedStart = 1'b1;
    @(negedge clk) seedStart = 1'b0;
    checkEq("R7 output cleared", envOut, 0);
    expectQuiet(40, "R7 no result after abandon");

    // R8: positive and negative saturation
    modelConst(32767, -30000, 30000, 30000, -30000);
    driveSeeds();
    strobeAndCheck("R8 saturation");
    checkEq("R8 clamp high", mI1[0], SMAX);
    checkEq("R8 clamp low", mQ1[0], SMIN);
    strobeAndCheck("R8 after saturation");

    // R4: all-zero seeds give a zero envelope
    modelConst(12000, 0, 0, 0, 0);
    driveSeeds();
    strobeAndCheck("R4 zero seeds");
    checkEq("R4 zero envelope", envOut, 0);

    summary();
  end
endmodule